// File: doc/BRIEF.md
# 1-Wire ROM Search Triplet Engine

This block speeds up the discovery of device identifiers on a 1-Wire bus. In search mode, the host hands the engine one byte at a time. Each byte covers four identifier bit positions. For every position the engine runs three bus slots. The first two are read slots, which return the bit that the devices present and then its complement. The third is a write slot, which sends the chosen direction. Devices that disagree with that direction drop out of the search.

When all four positions of the byte are done, the engine packs the result into one response byte. Each position contributes two bits: the bit that was selected and a flag that shows whether a conflict occurred there. The response appears on `rx_byte`, and `rx_full` rises at the same time.

Sixteen transfers give the full 64-bit identifier together with its conflict map, least significant nibble first. The engine does not produce bus waveforms. It asks a separate slot layer for each read or write slot and waits for that layer to report the slot complete.

Top module: `onew_srch_accel`

## Requirements
- R1: After reset `busy`, `slot_req` and `rx_full` are low and `rx_byte` is 0x00.
- R2: A write on `tx_valid` is ignored when `search_en` is low or when `busy` is high. In either case it starts no slot and changes neither `rx_full` nor `rx_byte`.
- R3: For each of the four positions of a byte, in order from 0 to 3, the engine requests two read slots (`slot_kind`=0) followed by one write slot (`slot_kind`=1).
- R4: If the two reads differ, the write slot sends the first read bit. The selected bit equals the first read bit and the flag is 0.
- R5: If both reads are 0, the write slot sends the preferred bit for position k, which is bit 2k+1 of the accepted transmit byte. The selected bit equals that preferred bit and the flag is 1. A transmit byte of 0x00 therefore takes the 0 branch at every conflict.
- R6: If both reads are 1, meaning no device answered, the write slot sends 1, and both the selected bit and the flag are 1.
- R7: In the response, bit 2k+1 holds the selected bit for position k and bit 2k holds the flag for position k.
- R8: `rx_full` rises, and `rx_byte` takes the new response, in the cycle after the fourth write slot completes. `rx_full` falls only when the next byte is accepted.
- R9: Dropping `search_en` aborts the byte in progress. From the next cycle, `slot_req` and `busy` are low and `rx_full` does not rise.
- R10: Sixteen transfers put together the 64-bit identifier and its conflict map, taking nibble t from transfer t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| search_en | input | 1 | Search mode enable |
| tx_valid | input | 1 | One-cycle strobe that offers `tx_byte` |
| tx_byte | input | 8 | Preferred directions, one in each odd bit |
| busy | output | 1 | A byte is in progress |
| slot_req | output | 1 | Slot request, held high until `slot_done` |
| slot_kind | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | One-cycle strobe: the current slot is finished |
| slot_rbit | input | 1 | Bus value sampled in a read slot, valid with `slot_done` |
| rx_byte | output | 8 | Packed response |
| rx_full | output | 1 | Response available |

## Verification
On every cycle, the assertions check the following from the ports alone:
- every write slot comes after exactly two read slots;
- the bit sent in each write slot follows the decision rule, given the reads and the preferred bit;
- `rx_full` rises only after the fourth write slot;
- the odd response bits equal the bits that were written;
- `rx_full` falls only on an accepted byte;
- a dropped enable stops slot requests within one cycle.

Some behaviours can only be shown by the bench's scenarios, against a bus model that responds to the engine:
- the flag values in the even response bits;
- a byte that is ignored because the engine is idle with the mode off, or busy;
- putting together a complete identifier over sixteen transfers, where the preferred direction decides which of two devices is found.

// File: rtl/onew_srch_pkg.sv
package onew_srch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDA  = 2'd1,
    ST_RDB  = 2'd2,
    ST_WR   = 2'd3
  } srch_st_e;

  localparam logic SLOT_READ  = 1'b0;
  localparam logic SLOT_WRITE = 1'b1;

  typedef struct packed {
    logic wbit;
    logic chosen;
    logic flag;
  } trip_res_t;

  // Decide one search step from the bit read, its complement and the host preference.
  function automatic trip_res_t triplet_decide(logic rd_a, logic rd_b, logic pref);
    trip_res_t r;
    if (rd_a != rd_b) begin
      r.wbit   = rd_a;
      r.chosen = rd_a;
      r.flag   = 1'b0;
    end else if (!rd_a) begin
      r.wbit   = pref;
      r.chosen = pref;
      r.flag   = 1'b1;
    end else begin
      r.wbit   = 1'b1;
      r.chosen = 1'b1;
      r.flag   = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/onew_srch_seq.sv
module onew_srch_seq
  import onew_srch_pkg::*;
#(
  parameter int NPOS = 4,
  localparam int DW  = 2 * NPOS,
  localparam int PW  = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          search_en,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          slot_done,
  input  logic          slot_rbit,
  output logic          slot_req,
  output logic          slot_kind,
  output logic          slot_wbit,
  output logic          busy,
  output logic          trip_done,
  output logic [PW-1:0] trip_pos,
  output trip_res_t     trip_res
);

  localparam logic [PW-1:0] LAST_POS = PW'(NPOS - 1);

  srch_st_e      st;
  logic [PW-1:0] pos;
  logic          rd_a, rd_b;
  logic [DW-1:0] tx_q;
  logic          pref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pos  <= '0;
      rd_a <= 1'b0;
      rd_b <= 1'b0;
      tx_q <= '0;
    end else if (!search_en) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st   <= ST_RDA;
          pos  <= '0;
          tx_q <= tx_byte;
        end
        ST_RDA: if (slot_done) begin
          rd_a <= slot_rbit;
          st   <= ST_RDB;
        end
        ST_RDB: if (slot_done) begin
          rd_b <= slot_rbit;
          st   <= ST_WR;
        end
        ST_WR: if (slot_done) begin
          if (pos == LAST_POS) begin
            st <= ST_IDLE;
          end else begin
            pos <= pos + 1'b1;
            st  <= ST_RDA;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pref      = tx_q[{pos, 1'b1}];
    trip_res  = triplet_decide(rd_a, rd_b, pref);
    slot_req  = (st != ST_IDLE);
    slot_kind = (st == ST_WR) ? SLOT_WRITE : SLOT_READ;
    slot_wbit = (st == ST_WR) ? trip_res.wbit : 1'b0;
    busy      = (st != ST_IDLE);
    trip_done = (st == ST_WR) && slot_done;
    trip_pos  = pos;
  end

endmodule

// File: rtl/onew_srch_pack.sv
module onew_srch_pack
  import onew_srch_pkg::*;
#(
  parameter int NPOS = 4,
  localparam int DW  = 2 * NPOS,
  localparam int PW  = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          trip_done,
  input  logic [PW-1:0] trip_pos,
  input  trip_res_t     trip_res,
  output logic [DW-1:0] rx_byte,
  output logic          rx_full,
  output logic          byte_done
);

  localparam logic [PW-1:0] LAST_POS = PW'(NPOS - 1);

  logic [DW-1:0] acc;
  logic [DW-1:0] acc_nxt;

  // Place the selected bit at 2k+1 and the flag at 2k for position k.
  function automatic logic [DW-1:0] put_pair(logic [DW-1:0] base, logic [PW-1:0] k,
                                             logic chosen, logic flag);
    logic [DW-1:0] v;
    v = base;
    for (int i = 0; i < NPOS; i++) begin
      if (PW'(i) == k) begin
        v[2*i+1] = chosen;
        v[2*i]   = flag;
      end
    end
    return v;
  endfunction

  always_comb begin
    acc_nxt   = put_pair(acc, trip_pos, trip_res.chosen, trip_res.flag);
    byte_done = trip_done && (trip_pos == LAST_POS) && !abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      rx_byte <= '0;
      rx_full <= 1'b0;
    end else if (start) begin
      acc     <= '0;
      rx_full <= 1'b0;
    end else if (byte_done) begin
      rx_byte <= acc_nxt;
      rx_full <= 1'b1;
    end else if (trip_done && !abort) begin
      acc <= acc_nxt;
    end
  end

endmodule

// File: rtl/onew_srch_accel.sv
module onew_srch_accel
  import onew_srch_pkg::*;
#(
  parameter int NPOS = 4,
  localparam int DW  = 2 * NPOS,
  localparam int PW  = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          search_en,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_byte,
  output logic          busy,
  output logic          slot_req,
  output logic          slot_kind,
  output logic          slot_wbit,
  input  logic          slot_done,
  input  logic          slot_rbit,
  output logic [DW-1:0] rx_byte,
  output logic          rx_full
);

  logic          accept;
  logic          trip_done;
  logic          byte_done;
  logic [PW-1:0] trip_pos;
  trip_res_t     trip_res;

  assign accept = tx_valid && search_en && !busy;

  onew_srch_seq #(.NPOS(NPOS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .search_en (search_en),
    .start     (accept),
    .tx_byte   (tx_byte),
    .slot_done (slot_done),
    .slot_rbit (slot_rbit),
    .slot_req  (slot_req),
    .slot_kind (slot_kind),
    .slot_wbit (slot_wbit),
    .busy      (busy),
    .trip_done (trip_done),
    .trip_pos  (trip_pos),
    .trip_res  (trip_res)
  );

  onew_srch_pack #(.NPOS(NPOS)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .abort     (!search_en),
    .trip_done (trip_done),
    .trip_pos  (trip_pos),
    .trip_res  (trip_res),
    .rx_byte   (rx_byte),
    .rx_full   (rx_full),
    .byte_done (byte_done)
  );

endmodule

// File: rtl/onew_srch_chk.sv
module onew_srch_chk #(
  parameter int NPOS = 4,
  localparam int DW  = 2 * NPOS,
  localparam int CW  = $clog2(NPOS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          search_en,
  input logic          tx_valid,
  input logic [DW-1:0] tx_byte,
  input logic          busy,
  input logic          slot_req,
  input logic          slot_kind,
  input logic          slot_wbit,
  input logic          slot_done,
  input logic          slot_rbit,
  input logic [DW-1:0] rx_byte,
  input logic          rx_full,
  input logic          byte_done
);

  logic          acc_ev;
  logic [DW-1:0] txc;
  logic [1:0]    rd_cnt;
  logic [CW-1:0] wr_cnt;
  logic          ra, rb;
  logic [NPOS-1:0] wlog;
  logic [NPOS-1:0] rx_odd;
  logic          exp_w;

  assign acc_ev = tx_valid && search_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc <= '0; rd_cnt <= '0; wr_cnt <= '0; ra <= 1'b0; rb <= 1'b0; wlog <= '0;
    end else if (!search_en || acc_ev) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
      if (acc_ev) txc <= tx_byte;
    end else if (slot_req && slot_done) begin
      if (!slot_kind) begin
        if (rd_cnt == 2'd0) ra <= slot_rbit;
        else rb <= slot_rbit;
        rd_cnt <= rd_cnt + 2'd1;
      end else begin
        rd_cnt <= '0;
        wr_cnt <= wr_cnt + 1'b1;
        for (int i = 0; i < NPOS; i++)
          if (CW'(i) == wr_cnt) wlog[i] <= slot_wbit;
      end
    end
  end

  for (genvar g = 0; g < NPOS; g++) begin : g_odd
    assign rx_odd[g] = rx_byte[2*g+1];
  end

  always_comb begin
    exp_w = 1'b1;
    if (ra != rb) exp_w = ra;
    else if (!ra) begin
      for (int i = 0; i < NPOS; i++)
        if (CW'(i) == wr_cnt) exp_w = txc[2*i+1];
    end
  end

  AST_WRITE_AFTER_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_kind) |-> (rd_cnt == 2'd2)); // R3
  AST_WRITE_BIT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_kind) |-> (slot_wbit == exp_w)); // R5
  AST_FULL_AFTER_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> (wr_cnt == CW'(NPOS))); // R8
  AST_FULL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_full); // R8
  AST_FULL_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(acc_ev)); // R8
  AST_CHOSEN_EQ_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> (rx_odd == wlog)); // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> (!slot_req && !busy)); // R9
  AST_IDLE_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !slot_req); // R2

endmodule

bind onew_srch_accel onew_srch_chk #(.NPOS(NPOS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .search_en (search_en),
  .tx_valid  (tx_valid),
  .tx_byte   (tx_byte),
  .busy      (busy),
  .slot_req  (slot_req),
  .slot_kind (slot_kind),
  .slot_wbit (slot_wbit),
  .slot_done (slot_done),
  .slot_rbit (slot_rbit),
  .rx_byte   (rx_byte),
  .rx_full   (rx_full),
  .byte_done (byte_done)
);

// File: tb/onew_srch_accel_tb.sv
module onew_srch_accel_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       search_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       busy, slot_req, slot_kind, slot_wbit;
  logic       slot_done = 1'b0;
  logic       slot_rbit = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_full;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  onew_srch_accel u_dut (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .busy(busy), .slot_req(slot_req), .slot_kind(slot_kind),
    .slot_wbit(slot_wbit), .slot_done(slot_done), .slot_rbit(slot_rbit),
    .rx_byte(rx_byte), .rx_full(rx_full)
  );

  // Bus model: scripted read bits, or two devices with identifiers.
  logic        dev_mode = 1'b0;
  logic [7:0]  script = 8'h00;
  logic [63:0] rom [2];
  logic [1:0]  active = 2'b11;
  int          idx = 0;
  int          rcount = 0, wcount = 0, rphase = 0, order_err = 0, nslots = 0, dly = 0;
  logic [3:0]  wlog = 4'h0;

  always @(negedge clk) begin
    if (slot_done) begin
      slot_done = 1'b0;
    end else if (slot_req) begin
      if (dly < 2) dly++;
      else begin
        dly = 0;
        nslots++;
        slot_done = 1'b1;
        if (!slot_kind) begin
          if (rphase >= 2) order_err++;
          if (dev_mode) begin
            logic v;
            v = 1'b1;
            for (int d = 0; d < 2; d++)
              if (active[d]) v = v & ((rphase == 0) ? rom[d][idx] : ~rom[d][idx]);
            slot_rbit = v;
          end else begin
            slot_rbit = script[rcount % 8];
          end
          rcount++;
          rphase++;
        end else begin
          if (rphase != 2) order_err++;
          rphase = 0;
          if (wcount < 4) wlog[wcount] = slot_wbit;
          wcount++;
          if (dev_mode) begin
            for (int d = 0; d < 2; d++)
              if (rom[d][idx] != slot_wbit) active[d] = 1'b0;
            idx++;
          end
        end
      end
    end else begin
      dly = 0;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_byte(input logic [7:0] tx, output logic [7:0] rx);
    rcount = 0; wcount = 0; rphase = 0; order_err = 0;
    while (busy) @(negedge clk);
    tx_byte = tx; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int n = 0; n < 300 && !rx_full; n++) @(negedge clk);
    rx = rx_byte;
  endtask

  // {read script, tx byte, expected response}; pair k of script: bit 2k first read, 2k+1 second.
  localparam logic [23:0] VEC [7] = '{
    {8'hAA, 8'h00, 8'h00},   // R4 reads 0/1 everywhere
    {8'h55, 8'hFF, 8'hAA},   // R4 reads 1/0 everywhere, preference unused
    {8'h00, 8'h00, 8'h55},   // R5 conflicts, 0x00 takes 0 branch
    {8'h00, 8'hFF, 8'hFF},   // R5 conflicts, prefer 1
    {8'h00, 8'h88, 8'hDD},   // R5 R7 mixed preferences
    {8'hFF, 8'h00, 8'hFF},   // R6 no device
    {8'hE1, 8'h0A, 8'hCE}    // R7 one of each case
  };

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  rx, held;
    logic [63:0] id, dmap;
    rom[0] = 64'h8A00_00F1_2345_6701;
    rom[1] = rom[0] ^ (64'h1 << 5) ^ (64'h1 << 40);

    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 slot_req", 64'(slot_req), 64'd0);
    check("R1 rx_full", 64'(rx_full), 64'd0);
    check("R1 rx_byte", 64'(rx_byte), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    search_en = 1'b1;

    for (int v = 0; v < 7; v++) begin
      script = VEC[v][23:16];
      run_byte(VEC[v][15:8], rx);
      check("R7 response", 64'(rx), 64'(VEC[v][7:0]));
      check("R8 rx_full", 64'(rx_full), 64'd1);
      check("R4 written bits", 64'(wlog), 64'({VEC[v][7], VEC[v][5], VEC[v][3], VEC[v][1]}));
      check("R3 slot order", 64'(order_err), 64'd0);
      check("R3 slot count", 64'(wcount * 16 + rcount), 64'(4 * 16 + 8));
    end

    // R2: ignored while mode off
    held = rx_byte;
    search_en = 1'b0;
    @(negedge clk);
    nslots = 0;
    tx_byte = 8'h00; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 no slots when off", 64'(nslots), 64'd0);
    check("R2 rx_full kept", 64'(rx_full), 64'd1);
    check("R2 rx_byte kept", 64'(rx_byte), 64'(held));
    search_en = 1'b1;

    // R2: a second strobe while busy is ignored
    script = 8'h00;
    rcount = 0; wcount = 0; rphase = 0;
    tx_byte = 8'h00; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    tx_byte = 8'hFF; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int n = 0; n < 300 && !rx_full; n++) @(negedge clk);
    check("R2 busy strobe ignored", 64'(rx_byte), 64'h55);

    // R9: abort mid-byte
    script = 8'h55;
    rcount = 0; wcount = 0; rphase = 0;
    tx_byte = 8'h00; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    while (wcount < 1) @(negedge clk);
    search_en = 1'b0;
    @(negedge clk);
    check("R9 slot_req low", 64'(slot_req), 64'd0);
    check("R9 busy low", 64'(busy), 64'd0);
    repeat (20) @(negedge clk);
    check("R9 rx_full not raised", 64'(rx_full), 64'd0);
    search_en = 1'b1;
    @(negedge clk);

    // R10: full identifier search, preference 0 then 1
    for (int p = 0; p < 2; p++) begin
      dev_mode = 1'b1; active = 2'b11; idx = 0;
      id = '0; dmap = '0;
      for (int t = 0; t < 16; t++) begin
        run_byte((p == 0) ? 8'h00 : 8'hFF, rx);
        for (int k = 0; k < 4; k++) begin
          id[4*t+k]   = rx[2*k+1];
          dmap[4*t+k] = rx[2*k];
        end
      end
      check("R10 identifier", id, rom[p]);
      check("R10 conflict map", dmap, 64'h1 << 5);
      check("R5 devices left", 64'(active), (p == 0) ? 64'd1 : 64'd2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule